// File: doc/BRIEF.md
# Paged Translation Entry Access Checker

The checker takes one translation entry pair that has already been picked out by a lookup stage. One half covers the even page of the pair and the other covers the odd page. The checker also takes the virtual address, the kind of access (instruction fetch, data load or data store), the current privilege level, the effective page-size exponent and a flag for wide (64-bit) or narrow (32-bit) addressing. It picks the half that covers the address and walks a fixed chain of fault checks. It returns one 3-bit verdict. On success it also returns the physical address and the read, write and execute grants that go with the page.

The decision logic is combinational and sits in front of a single output register. The register has a valid/ready handshake on both sides. A request is taken when `in_valid` and `in_ready` are both high. The result appears on the outputs one cycle later with `out_valid` set. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` is low, so the upstream side must hold its request. When the result is taken, a new request can be taken in the same cycle. The checker has no storage for entries, no lookup and no exception delivery.

Entry word layout, used by both halves (bit positions are part of the interface): bit 0 valid, bit 1 dirty/writable, bits 3:2 entry privilege level. In wide mode the frame number sits at bits PA_W-1:12, the no-read flag at bit 61, the no-execute flag at bit 62 and the restricted-privilege flag at bit 63. In narrow mode the frame number sits at bits 31:8.

Top module: `tlbchk_top`

## Requirements
- R1: The odd half (`in_entry_odd`) is used when virtual address bit `in_ps` is 1; otherwise the even half (`in_entry_even`) is used.
- R2: Faults are ranked as follows, and the first that applies decides the verdict: valid clear gives invalid; fetch (`in_access`=0) with no-execute set gives exec-inhibit; load (`in_access`=1) with no-read set gives read-inhibit; then the privilege fault; store (`in_access`=2) with dirty clear gives dirty fault.
- R3: With restricted-privilege clear, a privilege fault is raised when `in_plv` is numerically above the entry level. With restricted-privilege set, it is raised whenever `in_plv` differs from the entry level.
- R4: In narrow mode (`in_mode64`=0), bits 61, 62 and 63 have no effect and are taken as zero, and the frame number is read from bits 31:8.
- R5: On success, `out_pa` takes virtual address bits below `in_ps` and takes frame-number bits (frame number shifted left by 12) at and above `in_ps`. This drops frame bits between 12 and `in_ps`.
- R6: On success, read is always granted, write equals the dirty bit, and execute is the inverse of the effective no-execute flag. On any fault, `out_pa` and all three grants are zero.
- R7: Verdict codes on `out_code`: 0 success, 1 invalid, 2 exec-inhibit, 3 read-inhibit, 4 privilege fault, 5 dirty fault. No other value appears.
- R8: `in_ready` is low exactly while a result is held with `out_ready` low. A held result stays stable until taken. A request taken in one cycle sets `out_valid` in the next.
- R9: A synchronous active-high `rst` clears `out_valid`, and `in_ready` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_entry_even | input | 64 | Even-page half of the entry pair |
| in_entry_odd | input | 64 | Odd-page half of the entry pair |
| in_va | input | VA_W | Virtual address |
| in_access | input | 2 | 0 fetch, 1 load, 2 store |
| in_plv | input | 2 | Current privilege level |
| in_ps | input | 5 | Page-size exponent, 12 to 30 |
| in_mode64 | input | 1 | 1 wide layout, 0 narrow layout |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken by downstream |
| out_code | output | 3 | Verdict code |
| out_pa | output | PA_W | Physical address on success |
| out_perm_r | output | 1 | Read granted |
| out_perm_w | output | 1 | Write granted |
| out_perm_x | output | 1 | Execute granted |

## Verification
The assertions assume three things about the inputs: `in_access` never takes the spare value 3, `in_ps` stays within 12 to 30, and a stalled upstream holds its request. The stimulus sweeps only legal access kinds and a set of page sizes that includes both ends of the range. Each request is driven for exactly one handshake. During the stall test the request is held steady until `in_ready` returns. In the sweep, the unused half of the pair is always a fully permissive entry with a different frame number, so picking the wrong half shows up as a wrong verdict or a wrong address.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;

  localparam int ENT_W = 64;
  localparam int PS_W  = 5;
  localparam int PAGE_LSB = 12;

  // field positions inside one entry half
  localparam int F_VALID = 0;
  localparam int F_DIRTY = 1;
  localparam int F_PLV_LO = 2;
  localparam int F_NOREAD = 61;
  localparam int F_NOEXEC = 62;
  localparam int F_RESTR = 63;
  localparam int F32_FRAME_LO = 8;
  localparam int F32_FRAME_HI = 31;
  localparam int F32_FRAME_W = F32_FRAME_HI - F32_FRAME_LO + 1;

  typedef enum logic [2:0] {
    RES_OK        = 3'd0,
    RES_INVALID   = 3'd1,
    RES_EXEC_INH  = 3'd2,
    RES_READ_INH  = 3'd3,
    RES_PRIV      = 3'd4,
    RES_DIRTY     = 3'd5
  } res_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_SPARE = 2'd3
  } acc_e;

  typedef struct packed {
    logic       valid;
    logic       dirty;
    logic [1:0] plv;
    logic       noexec;
    logic       noread;
    logic       restr;
  } half_flags_t;

endpackage

// File: rtl/tlbchk_half_sel.sv
module tlbchk_half_sel
  import tlbchk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48
) (
  input  logic [ENT_W-1:0] entry_even,
  input  logic [ENT_W-1:0] entry_odd,
  input  logic [VA_W-1:0]  va,
  input  logic [PS_W-1:0]  ps,
  input  logic             mode64,
  output half_flags_t      flags,
  output logic [PA_W-1:0]  frame_base
);

  localparam int NARROW_W = F32_FRAME_W + PAGE_LSB;

  logic             odd_sel;
  logic [ENT_W-1:0] sel;
  logic [PA_W-1:0]  base_wide;
  logic [NARROW_W-1:0] base_narrow;

  // the address bit at the page-size position picks the half
  assign odd_sel = va[ps];
  assign sel     = odd_sel ? entry_odd : entry_even;

  always_comb begin
    flags.valid = sel[F_VALID];
    flags.dirty = sel[F_DIRTY];
    flags.plv   = sel[F_PLV_LO +: 2];
    // narrow layout has no room for these: force them off
    flags.noexec = mode64 & sel[F_NOEXEC];
    flags.noread = mode64 & sel[F_NOREAD];
    flags.restr  = mode64 & sel[F_RESTR];
  end

  assign base_wide   = {sel[PA_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
  assign base_narrow = {sel[F32_FRAME_HI:F32_FRAME_LO], {PAGE_LSB{1'b0}}};

  generate
    if (PA_W >= NARROW_W) begin : g_pad
      assign frame_base = mode64 ? base_wide
                                 : {{(PA_W-NARROW_W){1'b0}}, base_narrow};
    end else begin : g_trunc
      assign frame_base = mode64 ? base_wide : base_narrow[PA_W-1:0];
    end
  endgenerate

  logic unused_fields;
  assign unused_fields = ^{sel, va};

endmodule

// File: rtl/tlbchk_fault.sv
module tlbchk_fault
  import tlbchk_pkg::*;
(
  input  half_flags_t flags,
  input  acc_e        access,
  input  logic [1:0]  cur_plv,
  output res_e        code
);

  logic priv_bad;

  always_comb begin
    if (flags.restr) priv_bad = (cur_plv != flags.plv);
    else             priv_bad = (cur_plv > flags.plv);
  end

  // fixed ranking: earlier tests win
  always_comb begin
    if (!flags.valid)                              code = RES_INVALID;
    else if (access == ACC_FETCH && flags.noexec)  code = RES_EXEC_INH;
    else if (access == ACC_LOAD && flags.noread)   code = RES_READ_INH;
    else if (priv_bad)                             code = RES_PRIV;
    else if (access == ACC_STORE && !flags.dirty)  code = RES_DIRTY;
    else                                           code = RES_OK;
  end

endmodule

// File: rtl/tlbchk_pa_form.sv
module tlbchk_pa_form
  import tlbchk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48
) (
  input  logic [PA_W-1:0] frame_base,
  input  logic [VA_W-1:0] va,
  input  logic [PS_W-1:0] ps,
  output logic [PA_W-1:0] pa
);

  // per-bit merge: offset bits from the address, the rest from the frame
  generate
    for (genvar i = 0; i < PA_W; i++) begin : g_bit
      if (i < PAGE_LSB && i < VA_W) begin : g_low
        assign pa[i] = va[i];
      end else if (i < VA_W) begin : g_mid
        assign pa[i] = (int'(ps) > i) ? va[i] : frame_base[i];
      end else begin : g_high
        assign pa[i] = frame_base[i];
      end
    end
  endgenerate

  logic unused_in;
  assign unused_in = ^{frame_base, va};

endmodule

// File: rtl/tlbchk_top.sv
module tlbchk_top
  import tlbchk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [63:0]      in_entry_even,
  input  logic [63:0]      in_entry_odd,
  input  logic [VA_W-1:0]  in_va,
  input  logic [1:0]       in_access,
  input  logic [1:0]       in_plv,
  input  logic [4:0]       in_ps,
  input  logic             in_mode64,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_code,
  output logic [PA_W-1:0]  out_pa,
  output logic             out_perm_r,
  output logic             out_perm_w,
  output logic             out_perm_x
);

  half_flags_t     flags;
  logic [PA_W-1:0] frame_base;
  logic [PA_W-1:0] pa_raw;
  res_e            code_c;
  logic            ok_c;
  logic            take;

  tlbchk_half_sel #(.VA_W(VA_W), .PA_W(PA_W)) u_sel (
    .entry_even (in_entry_even),
    .entry_odd  (in_entry_odd),
    .va         (in_va),
    .ps         (in_ps),
    .mode64     (in_mode64),
    .flags      (flags),
    .frame_base (frame_base)
  );

  tlbchk_fault u_fault (
    .flags   (flags),
    .access  (acc_e'(in_access)),
    .cur_plv (in_plv),
    .code    (code_c)
  );

  tlbchk_pa_form #(.VA_W(VA_W), .PA_W(PA_W)) u_pa (
    .frame_base (frame_base),
    .va         (in_va),
    .ps         (in_ps),
    .pa         (pa_raw)
  );

  assign ok_c     = (code_c == RES_OK);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_code   <= RES_OK;
      out_pa     <= '0;
      out_perm_r <= 1'b0;
      out_perm_w <= 1'b0;
      out_perm_x <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_code   <= code_c;
      out_pa     <= ok_c ? pa_raw : '0;
      out_perm_r <= ok_c;
      out_perm_w <= ok_c && flags.dirty;
      out_perm_x <= ok_c && !flags.noexec;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/tlbchk_checker.sv
module tlbchk_checker #(
  parameter int VA_W = 48,
  parameter int PA_W = 48
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      in_access,
  input logic            in_mode64,
  input logic            out_valid,
  input logic            out_ready,
  input logic [2:0]      out_code,
  input logic [PA_W-1:0] out_pa,
  input logic            out_perm_r,
  input logic            out_perm_w,
  input logic            out_perm_x
);

  a_r9_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_code) &&
      $stable(out_pa) && $stable(out_perm_w) && $stable(out_perm_x));

  a_r8_take_shows: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  a_r7_code_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_code <= 3'd5);

  a_r6_read_on_ok: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_code == 3'd0 |-> out_perm_r);

  a_r6_fault_clean: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_code != 3'd0 |->
      !out_perm_r && !out_perm_w && !out_perm_x && out_pa == '0);

  a_r2_store_writable: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_access == 2'd2 |=>
      (out_code != 3'd0 || out_perm_w));

  a_r4_narrow_no_inhibit: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !in_mode64 |=>
      (out_code != 3'd2 && out_code != 3'd3 && out_perm_x == (out_code == 3'd0)));

endmodule

bind tlbchk_top tlbchk_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_access  (in_access),
  .in_mode64  (in_mode64),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_code   (out_code),
  .out_pa     (out_pa),
  .out_perm_r (out_perm_r),
  .out_perm_w (out_perm_w),
  .out_perm_x (out_perm_x)
);

// File: tb/tlbchk_top_tb.sv
`timescale 1ns/1ps
module tlbchk_top_tb;

  localparam int VA_W = 48;
  localparam int PA_W = 48;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [63:0]     in_entry_even = '0;
  logic [63:0]     in_entry_odd = '0;
  logic [VA_W-1:0] in_va = '0;
  logic [1:0]      in_access = '0;
  logic [1:0]      in_plv = '0;
  logic [4:0]      in_ps = 5'd12;
  logic            in_mode64 = 1'b1;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [2:0]      out_code;
  logic [PA_W-1:0] out_pa;
  logic            out_perm_r, out_perm_w, out_perm_x;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tlbchk_top #(.VA_W(VA_W), .PA_W(PA_W)) u_dut (.*);

  localparam logic [35:0] FRAME_W  = 36'h9_A5C3_F1E7;
  localparam logic [23:0] FRAME_N  = 24'hC3_A5F1;
  localparam logic [47:0] VA_BASE  = 48'h5A3C_9F17_E2B4;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_entry(bit v, bit d, logic [1:0] plv, bit nr,
      bit nx, bit rp, bit wide, logic [35:0] fw, logic [23:0] fn);
    logic [63:0] e = '0;
    e[0] = v; e[1] = d; e[3:2] = plv;
    e[61] = nr; e[62] = nx; e[63] = rp;
    if (wide) e[47:12] = fw; else e[31:8] = fn;
    return e;
  endfunction

  task automatic push(input logic [63:0] ev, input logic [63:0] od,
                      input logic [47:0] va, input logic [1:0] acc,
                      input logic [1:0] plv, input logic [4:0] ps, input bit wide);
    in_entry_even = ev; in_entry_odd = od; in_va = va;
    in_access = acc; in_plv = plv; in_ps = ps; in_mode64 = wide;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    automatic int ps_tab[5] = '{12, 13, 14, 20, 30};
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9 out_valid", 64'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R9 in_ready", 64'(in_ready), 1);

    // sweep: R1 R2 R3 R4 R5 R6 R7
    for (int pi = 0; pi < 5; pi++)
    for (int odd = 0; odd < 2; odd++)
    for (int wide = 0; wide < 2; wide++)
    for (int acc = 0; acc < 3; acc++)
    for (int cp = 0; cp < 4; cp++)
    for (int ep = 0; ep < 4; ep++)
    for (int fl = 0; fl < 32; fl++) begin
      automatic int ps = ps_tab[pi];
      automatic bit v = fl[0], d = fl[1], nx = fl[2], nr = fl[3], rp = fl[4];
      automatic bit enx = wide ? nx : 1'b0;
      automatic bit enr = wide ? nr : 1'b0;
      automatic bit erp = wide ? rp : 1'b0;
      automatic logic [63:0] tgt = mk_entry(v, d, ep[1:0], nr, nx, rp, wide[0],
                                            FRAME_W, FRAME_N);
      automatic logic [63:0] oth = mk_entry(1, 1, 2'd3, 0, 0, 0, wide[0],
                                            ~FRAME_W, ~FRAME_N);
      automatic logic [47:0] va = VA_BASE;
      automatic logic [47:0] msk = (48'd1 << ps) - 48'd1;
      automatic logic [47:0] base;
      automatic logic [47:0] exp_pa;
      automatic int ec;
      automatic string tag = wide ? "R2 R3 R7" : "R4 R7";
      va[ps] = odd[0];
      if (!v) ec = 1;
      else if (acc == 0 && enx) ec = 2;
      else if (acc == 1 && enr) ec = 3;
      else if ((!erp && cp > ep) || (erp && cp != ep)) ec = 4;
      else if (acc == 2 && !d) ec = 5;
      else ec = 0;
      base = wide ? {FRAME_W, 12'h0} : {12'h0, FRAME_N, 12'h0};
      exp_pa = (base & ~msk) | (va & msk);
      push(odd ? oth : tgt, odd ? tgt : oth, va, acc[1:0], cp[1:0], ps[4:0], wide[0]);
      check(out_valid && out_code == 3'(ec), tag, 64'(out_code), 64'(ec));
      if (ec == 0) begin
        check(out_pa == exp_pa, "R1 R5", 64'(out_pa), 64'(exp_pa));
        check(out_perm_r && out_perm_w == d && out_perm_x == !enx, "R6",
              64'({out_perm_r, out_perm_w, out_perm_x}),
              64'({1'b1, d, !enx}));
      end else begin
        check(out_pa == '0 && !out_perm_r && !out_perm_w && !out_perm_x, "R6",
              64'({out_pa, out_perm_r, out_perm_w, out_perm_x}), 0);
      end
    end

    // R8: stall and release
    @(negedge clk);
    out_ready = 1'b0;
    push(mk_entry(1, 1, 0, 0, 0, 0, 1, 36'h1, 24'h0), 64'h0, 48'h0, 2'd1, 2'd0, 5'd12, 1);
    check(out_valid && out_pa == 48'h1000, "R8 first", 64'(out_pa), 64'h1000);
    check(in_ready == 1'b0, "R8 ready low", 64'(in_ready), 0);
    in_entry_even = mk_entry(0, 0, 0, 0, 0, 0, 1, 36'h2, 24'h0);
    in_valid = 1'b1;
    repeat (2) @(negedge clk);
    check(out_code == 3'd0 && out_pa == 48'h1000, "R8 held",
          64'({out_code, out_pa}), 64'h1000);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_code == 3'd1, "R8 second", 64'(out_code), 1);
    @(negedge clk);
    check(!out_valid && in_ready, "R8 drained", 64'({out_valid, in_ready}), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule